// File: doc/BRIEF.md
# Interlaced Video Field Capture Gate

This block sits beside an interlaced video capture engine and decides, at the start of every incoming field, whether the engine stores that field. It drives a capture-active level that gates the data path for the whole field. In the non-continuous modes it also keeps sticky completion flags that host software reads and clears. Each field is judged on its own, using the enable, mode and select inputs sampled at that field's start pulse. The enable and the mode inputs therefore take effect only at the next field boundary, never in the middle of a field.

In continuous operation every enabled field is captured and no flag is ever touched. Otherwise a capture unit is either a single selected field or a whole frame (field 1 followed by field 2). Finishing a unit raises its flag. While that flag stays set, exactly one further unit is captured as a grace allowance. After that the block stops capturing, so the buffers the host has not yet serviced are not overwritten. At every later start of such a unit it looks at the flag again, and it starts capturing on its own once the host has cleared the flag. A one-cycle interrupt pulse marks every flag that goes from clear to set.

Top module: `vid_field_gate`

## Requirements
- R1: After a synchronous active-low reset, capture_active is low, all three flags (f1_done, f2_done, frame_done) are clear and irq is low.
- R2: A field whose start pulse arrives while cap_en is low is not captured, in any mode. A field already being captured when cap_en falls is captured to its end.
- R3: With cont_mode high, every enabled field is captured (capture_active is high from the cycle after sof until the cycle after eof), and no flag is set.
- R4: With cont_mode and frame_mode low and only one select high (sel_f1 for field 1, sel_f2 for field 2), only that field is captured. Its flag is set in the cycle after its eof. The other field leaves capture_active low and sets no flag. sof_field is 0 for field 1 and 1 for field 2.
- R5: With cont_mode and frame_mode low and both selects high, each field is captured and sets its own flag.
- R6: With frame_mode high and cont_mode low, field 1 and the field 2 that follows it are both captured, and frame_done is set in the cycle after field 2's eof. A field 2 whose frame's field 1 was not captured is not captured.
- R7: While a unit's flag is set, exactly one further unit of that kind is captured. The next one is not captured.
- R8: At the start of each not-captured unit, the block checks the flag again. Once the host has cleared it, that unit is captured and the grace allowance is restored.
- R9: The clear strobes (clr_f1_done, clr_f2_done, clr_frame_done) clear their flag one cycle later. A hardware set in the same cycle wins, and the flag stays set.
- R10: irq is high for exactly one cycle, the cycle after a flag goes from 0 to 1. Ending a unit whose flag is already set gives no irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_en | input | 1 | Capture enable, sampled at each field start |
| cont_mode | input | 1 | 1: capture all fields with no flags or halting |
| frame_mode | input | 1 | 1: the capture unit is a whole frame |
| sel_f1 | input | 1 | Field-mode select for field 1 |
| sel_f2 | input | 1 | Field-mode select for field 2 |
| sof | input | 1 | One-cycle start-of-field pulse |
| sof_field | input | 1 | Field number with sof: 0 field 1, 1 field 2 |
| eof | input | 1 | One-cycle end-of-field pulse |
| clr_f1_done | input | 1 | Write-one-to-clear strobe for f1_done |
| clr_f2_done | input | 1 | Write-one-to-clear strobe for f2_done |
| clr_frame_done | input | 1 | Write-one-to-clear strobe for frame_done |
| capture_active | output | 1 | High while the current field is being stored |
| f1_done | output | 1 | Sticky field-1 completion flag |
| f2_done | output | 1 | Sticky field-2 completion flag |
| frame_done | output | 1 | Sticky frame completion flag |
| irq | output | 1 | One-cycle pulse on any flag rising |

## Verification
The hardest state to reach from the ports is a halted unit. Getting there takes a completed unit, a grace unit that finishes while the flag is still set, and a third unit start with the flag untouched. Only after that can the resume on a cleared flag be seen. The vector table walks long chains of fields with no reset between them, so the grace allowances left behind in field mode and in frame mode carry into later rows. This covers the mixed case where one select is halted while the other still has its grace unit. A directed test puts a clear strobe in the same cycle as a flag-setting eof.

// File: rtl/vfg_pkg.sv
// Shared types for the video field capture gate.
// Assumes three completion flags, held in the fixed bit order below.
package vfg_pkg;

    localparam int NUM_FLAGS = 3;
    localparam int FLAG_W    = $clog2(NUM_FLAGS);

    localparam int FLAG_F1  = 0;
    localparam int FLAG_F2  = 1;
    localparam int FLAG_FRM = 2;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_CAPTURING = 2'd1,
        ST_GRACE     = 2'd2,
        ST_HALTED    = 2'd3
    } cap_state_e;

endpackage

// File: rtl/vfg_decide.sv
// Per-field capture decision, purely combinational.
// Evaluated with the start-of-field pulse. Picks the capture unit from the
// mode bits, then captures freely, captures under the grace allowance, or halts.
// Assumes the flag and grace inputs are the registered values for this cycle.
module vfg_decide
    import vfg_pkg::*;
(
    input  logic                 cap_en_i,
    input  logic                 cont_i,
    input  logic                 frame_i,
    input  logic                 sel_f1_i,
    input  logic                 sel_f2_i,
    input  logic                 field_i,
    input  logic                 frame_open_i,
    input  logic [NUM_FLAGS-1:0] flag_i,
    input  logic [NUM_FLAGS-1:0] grace_i,
    output logic                 capture_o,
    output logic                 halt_o,
    output cap_state_e           state_o,
    output logic [NUM_FLAGS-1:0] end_mask_o,
    output logic [NUM_FLAGS-1:0] grace_set_o,
    output logic [NUM_FLAGS-1:0] grace_clr_o,
    output logic                 frame_open_o
);

    logic              gated_unit;
    logic [FLAG_W-1:0] unit_idx;

    // Purpose: pick which flag, if any, governs the field now starting.
    always_comb begin
        gated_unit = 1'b0;
        unit_idx   = FLAG_W'(FLAG_F1);
        if (cap_en_i && !cont_i) begin
            if (frame_i) begin
                gated_unit = !field_i;
                unit_idx   = FLAG_W'(FLAG_FRM);
            end else if (field_i) begin
                gated_unit = sel_f2_i;
                unit_idx   = FLAG_W'(FLAG_F2);
            end else begin
                gated_unit = sel_f1_i;
                unit_idx   = FLAG_W'(FLAG_F1);
            end
        end
    end

    // Purpose: turn mode, flag and grace state into the capture verdict.
    always_comb begin
        capture_o    = 1'b0;
        halt_o       = 1'b0;
        state_o      = ST_IDLE;
        end_mask_o   = '0;
        grace_set_o  = '0;
        grace_clr_o  = '0;
        frame_open_o = 1'b0;
        if (cap_en_i && cont_i) begin
            capture_o = 1'b1;
            state_o   = ST_CAPTURING;
        end else if (cap_en_i && frame_i && field_i) begin
            if (frame_open_i) begin
                capture_o            = 1'b1;
                state_o              = ST_CAPTURING;
                end_mask_o[FLAG_FRM] = 1'b1;
            end
        end else if (gated_unit) begin
            if (!flag_i[unit_idx]) begin
                capture_o             = 1'b1;
                state_o               = ST_CAPTURING;
                grace_clr_o[unit_idx] = 1'b1;
            end else if (!grace_i[unit_idx]) begin
                capture_o             = 1'b1;
                state_o               = ST_GRACE;
                grace_set_o[unit_idx] = 1'b1;
            end else begin
                halt_o  = 1'b1;
                state_o = ST_HALTED;
            end
            if (frame_i) begin
                frame_open_o = capture_o;
            end else begin
                end_mask_o[unit_idx] = capture_o;
            end
        end
    end

endmodule

// File: rtl/vfg_status.sv
// Sticky write-one-to-clear completion flags with a shared interrupt pulse.
// A hardware set beats a host clear arriving in the same cycle. The interrupt
// fires one cycle after any flag rises from 0 to 1.
module vfg_status #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o,
    output logic         irq_o
);

    logic [N-1:0] rise;
    logic         irq_q;

    for (genvar k = 0; k < N; k++) begin : g_flag
        logic bit_q;

        // Purpose: hold one sticky flag, with set taking priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else begin
                bit_q <= set_i[k] | (bit_q & ~clr_i[k]);
            end
        end

        assign flag_o[k] = bit_q;
        assign rise[k]   = set_i[k] & ~bit_q;

        assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[k] |=> bit_q);
        assert_clear_works_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[k] && !set_i[k]) |=> !bit_q);
    end

    // Purpose: register a one-cycle interrupt for any new flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |rise;
        end
    end

    assign irq_o = irq_q;

    assert_irq_on_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_i & ~flag_o)) |=> irq_o);
    assert_no_irq_without_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == '0) |=> !irq_o);

endmodule

// File: rtl/vid_field_gate.sv
// Field-by-field capture gate for an interlaced video capture engine.
// Samples enable and mode at every start-of-field pulse, keeps the grace
// allowance for each flag, and drives capture_active until end of field.
// Assumes sof and eof never pulse in the same cycle.
module vid_field_gate
    import vfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cap_en,
    input  logic cont_mode,
    input  logic frame_mode,
    input  logic sel_f1,
    input  logic sel_f2,
    input  logic sof,
    input  logic sof_field,
    input  logic eof,
    input  logic clr_f1_done,
    input  logic clr_f2_done,
    input  logic clr_frame_done,
    output logic capture_active,
    output logic f1_done,
    output logic f2_done,
    output logic frame_done,
    output logic irq
);

    cap_state_e           state_q;
    logic [NUM_FLAGS-1:0] end_mask_q;
    logic [NUM_FLAGS-1:0] grace_q;
    logic                 frame_open_q;
    logic [NUM_FLAGS-1:0] flags;
    logic [NUM_FLAGS-1:0] hw_set;
    logic [NUM_FLAGS-1:0] host_clr;

    logic                 dec_capture;
    logic                 dec_halt;
    cap_state_e           dec_state;
    logic [NUM_FLAGS-1:0] dec_end_mask;
    logic [NUM_FLAGS-1:0] dec_grace_set;
    logic [NUM_FLAGS-1:0] dec_grace_clr;
    logic                 dec_frame_open;

    vfg_decide u_decide (
        .cap_en_i     (cap_en),
        .cont_i       (cont_mode),
        .frame_i      (frame_mode),
        .sel_f1_i     (sel_f1),
        .sel_f2_i     (sel_f2),
        .field_i      (sof_field),
        .frame_open_i (frame_open_q),
        .flag_i       (flags),
        .grace_i      (grace_q),
        .capture_o    (dec_capture),
        .halt_o       (dec_halt),
        .state_o      (dec_state),
        .end_mask_o   (dec_end_mask),
        .grace_set_o  (dec_grace_set),
        .grace_clr_o  (dec_grace_clr),
        .frame_open_o (dec_frame_open)
    );

    assign capture_active = (state_q == ST_CAPTURING) || (state_q == ST_GRACE);

    // Purpose: field-level state, latched at sof and closed at eof.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            end_mask_q   <= '0;
            grace_q      <= '0;
            frame_open_q <= 1'b0;
        end else if (sof) begin
            state_q      <= dec_state;
            end_mask_q   <= dec_end_mask;
            grace_q      <= (grace_q & ~dec_grace_clr) | dec_grace_set;
            frame_open_q <= dec_frame_open;
        end else if (eof && capture_active) begin
            state_q    <= ST_IDLE;
            end_mask_q <= '0;
        end
    end

    // Purpose: a unit-ending field raises its flag as the field closes.
    always_comb begin
        hw_set = (eof && !sof && capture_active) ? end_mask_q : '0;
    end

    assign host_clr = {clr_frame_done, clr_f2_done, clr_f1_done};

    vfg_status #(.N(NUM_FLAGS)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (hw_set),
        .clr_i  (host_clr),
        .flag_o (flags),
        .irq_o  (irq)
    );

    assign f1_done    = flags[FLAG_F1];
    assign f2_done    = flags[FLAG_F2];
    assign frame_done = flags[FLAG_FRM];

    assert_disabled_field_skipped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sof && !cap_en) |=> !capture_active);
    assert_field_runs_to_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_active && !eof && !sof) |=> capture_active);
    assert_continuous_captures_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sof && cap_en && cont_mode) |=> capture_active);
    assert_continuous_no_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sof && cont_mode) |=> (end_mask_q == '0));
    assert_single_flag_per_field_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> $onehot0(end_mask_q));
    assert_halt_blocks_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sof && dec_halt) |=> (!capture_active && state_q == ST_HALTED));
    assert_clear_flag_resumes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sof && dec_capture) |=> capture_active);

endmodule

// File: tb/vid_field_gate_test.sv
`timescale 1ns/1ps
module vid_field_gate_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cap_en = 1'b0, cont_mode = 1'b0, frame_mode = 1'b0;
    logic sel_f1 = 1'b0, sel_f2 = 1'b0;
    logic sof = 1'b0, sof_field = 1'b0, eof = 1'b0;
    logic clr_f1_done = 1'b0, clr_f2_done = 1'b0, clr_frame_done = 1'b0;
    logic capture_active, f1_done, f2_done, frame_done, irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    vid_field_gate uut (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cont_mode(cont_mode),
        .frame_mode(frame_mode), .sel_f1(sel_f1), .sel_f2(sel_f2),
        .sof(sof), .sof_field(sof_field), .eof(eof),
        .clr_f1_done(clr_f1_done), .clr_f2_done(clr_f2_done),
        .clr_frame_done(clr_frame_done), .capture_active(capture_active),
        .f1_done(f1_done), .f2_done(f2_done), .frame_done(frame_done), .irq(irq)
    );

    // Row: en cont frame s1 s2 fld | clr{frm,f2,f1} | cap | flags{frm,f2,f1} | irq
    localparam int NV = 23;
    localparam logic [13:0] VEC [NV] = '{
        14'b0_0_0_1_0_0_000_0_000_0, // R2 disabled
        14'b1_1_0_0_0_0_000_1_000_0, // R3 continuous f1
        14'b1_1_0_0_0_1_000_1_000_0, // R3 continuous f2
        14'b1_0_0_1_0_0_000_1_001_1, // R4 f1 captured, flag
        14'b1_0_0_1_0_1_000_0_001_0, // R4 f2 ignored
        14'b1_0_0_1_0_0_000_1_001_0, // R7 grace field
        14'b1_0_0_1_0_0_000_0_001_0, // R7 halted
        14'b1_0_0_1_0_0_000_0_001_0, // R8 still halted
        14'b1_0_0_1_0_0_001_1_001_1, // R8 resume after clear
        14'b1_0_0_1_0_0_000_1_001_0, // R7 grace again
        14'b1_0_0_0_1_1_000_1_011_1, // R4 f2 only
        14'b1_0_0_0_1_0_000_0_011_0, // R4 f1 ignored
        14'b1_0_0_1_1_0_000_0_011_0, // R5 f1 halted
        14'b1_0_0_1_1_1_000_1_011_0, // R5 f2 grace
        14'b1_0_1_0_0_0_011_1_000_0, // R6 frame f1
        14'b1_0_1_0_0_1_000_1_100_1, // R6 frame f2, flag
        14'b1_0_1_0_0_0_000_1_100_0, // R7 frame grace f1
        14'b1_0_1_0_0_1_000_1_100_0, // R7 frame grace f2
        14'b1_0_1_0_0_0_000_0_100_0, // R7 frame halted f1
        14'b1_0_1_0_0_1_000_0_100_0, // R6 orphan f2
        14'b1_0_1_0_0_1_100_0_000_0, // R6 orphan f2 after clear
        14'b1_0_1_0_0_0_000_1_000_0, // R8 frame resumes
        14'b1_0_1_0_0_1_000_1_100_1  // R6 frame done again
    };

    task automatic check(input string req, input string what,
                         input logic [3:0] act, input logic [3:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [3:0] flags_now();
        return {1'b0, frame_done, f2_done, f1_done};
    endfunction

    task automatic pulse_clr(input logic [2:0] c);
        {clr_frame_done, clr_f2_done, clr_f1_done} = c;
        tick(1);
        {clr_frame_done, clr_f2_done, clr_f1_done} = 3'b000;
    endtask

    task automatic start_field(input logic fld);
        sof = 1'b1; sof_field = fld;
        tick(1);
        sof = 1'b0;
    endtask

    task automatic end_field();
        eof = 1'b1;
        tick(1);
        eof = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        tick(1);
        do_reset();
        check("R1", "capture after reset", {3'b0, capture_active}, 4'h0);
        check("R1", "flags after reset", flags_now(), 4'h0);
        check("R1", "irq after reset", {3'b0, irq}, 4'h0);

        for (int v = 0; v < NV; v++) begin
            {cap_en, cont_mode, frame_mode, sel_f1, sel_f2} = VEC[v][13:9];
            if (VEC[v][7:5] != 3'b000) pulse_clr(VEC[v][7:5]);
            start_field(VEC[v][8]);
            tick(3);
            check($sformatf("R%0d row%0d", 2, v), "capture mid-field",
                  {3'b0, capture_active}, {3'b0, VEC[v][4]});
            end_field();
            check($sformatf("vector row%0d", v), "flags after eof",
                  flags_now(), {1'b0, VEC[v][3:1]});
            check($sformatf("R10 row%0d", v), "irq after eof",
                  {3'b0, irq}, {3'b0, VEC[v][0]});
            check($sformatf("R3 row%0d", v), "capture after eof",
                  {3'b0, capture_active}, 4'h0);
            tick(1);
            check($sformatf("R10 row%0d", v), "irq one cycle only",
                  {3'b0, irq}, 4'h0);
        end

        // R2: enable dropped mid-field, the field still finishes
        do_reset();
        {cap_en, cont_mode, frame_mode, sel_f1, sel_f2} = 5'b11000;
        start_field(1'b0);
        tick(2);
        cap_en = 1'b0;
        tick(2);
        check("R2", "capture held after enable drop", {3'b0, capture_active}, 4'h1);
        end_field();
        check("R2", "capture ends at eof", {3'b0, capture_active}, 4'h0);
        start_field(1'b1);
        tick(1);
        check("R2", "next field not captured", {3'b0, capture_active}, 4'h0);
        end_field();

        // R9: a clear strobe in the same cycle as a set is lost
        do_reset();
        {cap_en, cont_mode, frame_mode, sel_f1, sel_f2} = 5'b10010;
        start_field(1'b0); tick(1); end_field(); tick(1);
        check("R9", "f1 flag set", flags_now(), 4'h1);
        start_field(1'b0); tick(1);
        check("R7", "grace field captured", {3'b0, capture_active}, 4'h1);
        eof = 1'b1; clr_f1_done = 1'b1;
        tick(1);
        eof = 1'b0; clr_f1_done = 1'b0;
        check("R9", "set beats clear", flags_now(), 4'h1);
        check("R10", "no irq on already-set flag", {3'b0, irq}, 4'h0);
        pulse_clr(3'b001);
        check("R9", "plain clear", flags_now(), 4'h0);

        // R1: reset in mid-run clears flags
        start_field(1'b0); tick(1); end_field(); tick(1);
        rst_n = 1'b0; tick(2);
        check("R1", "flags cleared by reset", flags_now(), 4'h0);
        check("R1", "capture low in reset", {3'b0, capture_active}, 4'h0);
        rst_n = 1'b1; tick(1);
        check("R1", "irq low after reset", {3'b0, irq}, 4'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule